// File: doc/BRIEF.md
# Serial Second-Order IIR Section Evaluator

This block computes one output sample of a second-order recursive filter section. The caller pulses a start strobe with all ten operands present on the input ports. The operands are three feed-forward gains, two feedback gains, the current and two previous input samples, and the two previous outputs. The block registers the operands at that edge, so the caller may change the inputs at once. It then walks a fixed schedule of five products and four sums. A single shared multiplier and a single shared adder do the arithmetic, and each is a pipeline with a fixed latency set by a parameter. After the last sum, a one-cycle done pulse announces the result. The block keeps no filter history: the caller supplies the past samples and feeds the result back on the next call.

All data is signed fixed point with two integer bits and thirty fraction bits (Q2.30) in 32-bit words. Every term is added, so the filter's sign convention is carried entirely by the coefficient values. Only one arithmetic operation is in flight at any time. The multiplier keeps its pipeline short and gives a latency that does not depend on the data.

Top module: `biquad_serial_eval`

## Requirements
- R1: With operands captured at an accepted start, the result is sat(sat(sat(sat(P0+P1)+P2)+P3)+P4). Here P0=g0·x0, P1=g1·x1, P2=g2·x2, P3=h1·v1 and P4=h2·v2, and all values are Q2.30 two's complement (0x40000000 is 1.0).
- R2: Each product is formed at full 64-bit width, has 2^29 added (ties round toward plus infinity), and is arithmetically shifted right by 30. It then saturates to 0x7FFFFFFF or 0x80000000 when it is out of the 32-bit range.
- R3: Each sum that overflows 32 bits gives 0x7FFFFFFF (positive overflow) or 0x80000000 (negative overflow) and does not wrap.
- R4: If start is sampled high while idle at clock edge N, then done is high in the cycle that follows edge N+9·LAT+9, for every LAT ≥ 1.
- R5: busy_o goes high after the edge that accepts start and stays high until done. done_o is high for exactly one cycle, and busy_o is low during that cycle.
- R6: y_o changes only in a cycle where done_o is high, and otherwise holds the last result.
- R7: A start pulse that arrives while busy_o is high is ignored: it changes neither the result nor the completion cycle.
- R8: A change on any operand input after the accepting edge does not affect the result.
- R9: While rst_n is low, busy_o, done_o and y_o are zero and any evaluation in progress is abandoned. A start is accepted from the third rising edge after rst_n goes high.
- R10: The sums are formed in a fixed order: P0+P1 first, then +P2, +P3, +P4. Saturation is applied after each sum, so 0x7FFFFFFF plus −1.0 (0xC0000000) yields 0x3FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request, all operands valid |
| g0_i | input | DW | Gain on the current input sample |
| g1_i | input | DW | Gain on the input sample one step back |
| g2_i | input | DW | Gain on the input sample two steps back |
| h1_i | input | DW | Gain on the output one step back |
| h2_i | input | DW | Gain on the output two steps back |
| x0_i | input | DW | Current input sample |
| x1_i | input | DW | Input sample one step back |
| x2_i | input | DW | Input sample two steps back |
| v1_i | input | DW | Output sample one step back |
| v2_i | input | DW | Output sample two steps back |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle result strobe |
| y_o | output | DW | Result, held between strobes |

## Verification
A wrong schedule index or a missed result capture shows up directly at the ports. A wrong index either feeds the wrong gain and sample pair into a product, or routes a product into the wrong accumulator slot. A missed capture leaves the controller waiting forever or moves done. Either way, the error appears at the first done pulse after the bad step, about 9·LAT+9 cycles after the start at most. The chosen operands give every product a value distinct from the others, and a saturating sum leads into a negative term, so the result differs for each of these faults. The completion cycle is compared exactly at three latency settings, so a single-cycle slip in the handshake between the controller and a pipeline's valid bit is caught on the first request.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } bq_state_e;

  typedef logic [3:0] op_idx_t;

  localparam op_idx_t LAST_OP = 4'd8;

  // schedule slots that use the multiplier; the others use the adder
  function automatic logic bq_is_mul(input op_idx_t idx);
    return (idx == 4'd0) || (idx == 4'd1) || (idx == 4'd3) ||
           (idx == 4'd5) || (idx == 4'd7);
  endfunction

endpackage

// File: rtl/bq_delay.sv
module bq_delay #(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  logic [W-1:0] dat_q [LAT];
  logic         vld_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
          dat_q[s] <= '0;
        end else begin
          vld_q[s] <= in_vld;
          if (in_vld) dat_q[s] <= in_dat;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
          dat_q[s] <= '0;
        end else begin
          vld_q[s] <= vld_q[s-1];
          if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
        end
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_dat = dat_q[LAT-1];

endmodule

// File: rtl/bq_mul_pipe.sv
module bq_mul_pipe #(
  parameter int DW   = 32,
  parameter int FRAC = 30,
  parameter int LAT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          vld_o,
  output logic [DW-1:0] res_o
);

  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] HALF = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] ae, be, prod, shr;
  logic [DW-1:0]        res_c;

  always_comb begin
    ae   = {{DW{a_i[DW-1]}}, a_i};
    be   = {{DW{b_i[DW-1]}}, b_i};
    prod = ae * be;
    shr  = (prod + HALF) >>> FRAC;
    if (shr > MAXV)      res_c = MAXV[DW-1:0];
    else if (shr < MINV) res_c = MINV[DW-1:0];
    else                 res_c = shr[DW-1:0];
  end

  bq_delay #(.W(DW), .LAT(LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(go_i), .in_dat(res_c),
    .out_vld(vld_o), .out_dat(res_o)
  );

endmodule

// File: rtl/bq_add_pipe.sv
module bq_add_pipe #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          vld_o,
  output logic [DW-1:0] res_o
);

  logic [DW:0]   sum;
  logic [DW-1:0] res_c;

  always_comb begin
    sum = {a_i[DW-1], a_i} + {b_i[DW-1], b_i};
    if (sum[DW] != sum[DW-1]) res_c = {sum[DW], {(DW-1){~sum[DW]}}};
    else                      res_c = sum[DW-1:0];
  end

  bq_delay #(.W(DW), .LAT(LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(go_i), .in_dat(res_c),
    .out_vld(vld_o), .out_dat(res_o)
  );

endmodule

// File: rtl/bq_ctrl.sv
module bq_ctrl
  import biquad_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mul_vld_i,
  input  logic [DW-1:0] mul_res_i,
  input  logic          add_vld_i,
  input  logic [DW-1:0] add_res_i,
  output op_idx_t       op_o,
  output logic          mul_go_o,
  output logic          add_go_o,
  output logic [DW-1:0] add_a_o,
  output logic [DW-1:0] add_b_o,
  output logic          cap_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] y_o
);

  bq_state_e     state_q, state_d;
  op_idx_t       op_q, op_d;
  logic          is_mul, take, fin;
  logic          p_en, q_en, acc_en;
  logic [DW-1:0] p_q, q_q, acc_q, y_q;
  logic          done_q;

  // next-state process
  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    cap_en_o = 1'b0;
    mul_go_o = 1'b0;
    add_go_o = 1'b0;
    fin      = 1'b0;
    is_mul   = bq_is_mul(op_q);
    take     = (state_q == ST_WAIT) && (is_mul ? mul_vld_i : add_vld_i);
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en_o = 1'b1;
          op_d     = '0;
          state_d  = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        mul_go_o = is_mul;
        add_go_o = !is_mul;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (take) begin
          if (op_q == LAST_OP) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            op_d    = op_q + 4'd1;
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    p_en   = take && is_mul && (op_q != 4'd1);
    q_en   = take && (op_q == 4'd1);
    acc_en = take && !is_mul;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      p_q     <= '0;
      q_q     <= '0;
      acc_q   <= '0;
      y_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      done_q  <= fin;
      if (p_en)   p_q   <= mul_res_i;
      if (q_en)   q_q   <= mul_res_i;
      if (acc_en) acc_q <= add_res_i;
      if (fin)    y_q   <= add_res_i;
    end
  end

  // first sum joins the two leading products; later sums extend the total
  assign add_a_o = (op_q == 4'd2) ? p_q : acc_q;
  assign add_b_o = (op_q == 4'd2) ? q_q : p_q;
  assign op_o    = op_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign y_o     = y_q;

endmodule

// File: rtl/biquad_serial_eval.sv
module biquad_serial_eval
  import biquad_pkg::*;
#(
  parameter int DW   = 32,
  parameter int FRAC = 30,
  parameter int LAT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] g0_i,
  input  logic [DW-1:0] g1_i,
  input  logic [DW-1:0] g2_i,
  input  logic [DW-1:0] h1_i,
  input  logic [DW-1:0] h2_i,
  input  logic [DW-1:0] x0_i,
  input  logic [DW-1:0] x1_i,
  input  logic [DW-1:0] x2_i,
  input  logic [DW-1:0] v1_i,
  input  logic [DW-1:0] v2_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] y_o
);

  localparam int NOPND = 10;
  localparam int IG0 = 0, IG1 = 1, IG2 = 2, IH1 = 3, IH2 = 4;
  localparam int IX0 = 5, IX1 = 6, IX2 = 7, IV1 = 8, IV2 = 9;

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [DW-1:0] opnd_in [NOPND];
  logic [DW-1:0] opnd_q  [NOPND];
  op_idx_t       op;
  logic          cap_en, mul_go, add_go, mul_vld, add_vld;
  logic [DW-1:0] mul_a, mul_b, mul_res, add_a, add_b, add_res;

  // reset asserts at once, releases on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    opnd_in[IG0] = g0_i;  opnd_in[IG1] = g1_i;  opnd_in[IG2] = g2_i;
    opnd_in[IH1] = h1_i;  opnd_in[IH2] = h2_i;
    opnd_in[IX0] = x0_i;  opnd_in[IX1] = x1_i;  opnd_in[IX2] = x2_i;
    opnd_in[IV1] = v1_i;  opnd_in[IV2] = v2_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NOPND; i++) opnd_q[i] <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < NOPND; i++) opnd_q[i] <= opnd_in[i];
    end
  end

  always_comb begin
    case (op)
      4'd0:    begin mul_a = opnd_q[IG0]; mul_b = opnd_q[IX0]; end
      4'd1:    begin mul_a = opnd_q[IG1]; mul_b = opnd_q[IX1]; end
      4'd3:    begin mul_a = opnd_q[IG2]; mul_b = opnd_q[IX2]; end
      4'd5:    begin mul_a = opnd_q[IH1]; mul_b = opnd_q[IV1]; end
      4'd7:    begin mul_a = opnd_q[IH2]; mul_b = opnd_q[IV2]; end
      default: begin mul_a = '0;          mul_b = '0;          end
    endcase
  end

  bq_mul_pipe #(.DW(DW), .FRAC(FRAC), .LAT(LAT)) u_mul (
    .clk(clk), .rst_n(rst_sync_n), .go_i(mul_go), .a_i(mul_a), .b_i(mul_b),
    .vld_o(mul_vld), .res_o(mul_res)
  );

  bq_add_pipe #(.DW(DW), .LAT(LAT)) u_add (
    .clk(clk), .rst_n(rst_sync_n), .go_i(add_go), .a_i(add_a), .b_i(add_b),
    .vld_o(add_vld), .res_o(add_res)
  );

  bq_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .mul_vld_i(mul_vld), .mul_res_i(mul_res),
    .add_vld_i(add_vld), .add_res_i(add_res),
    .op_o(op), .mul_go_o(mul_go), .add_go_o(add_go),
    .add_a_o(add_a), .add_b_o(add_b), .cap_en_o(cap_en),
    .busy_o(busy_o), .done_o(done_o), .y_o(y_o)
  );

endmodule

// File: rtl/bq_eval_chk.sv
module bq_eval_chk #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] y_o
);

  localparam int TOTAL = 9 * LAT + 10;

  logic [15:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc_q <= '0;
    else if (start_i && !busy_o) cyc_q <= 16'd1;
    else if (busy_o)            cyc_q <= cyc_q + 16'd1;
  end

  // R4
  latency_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q == 16'(TOTAL)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(y_o));

  // R7
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind biquad_serial_eval bq_eval_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .y_o(y_o)
);

// File: tb/tb_biquad_serial_eval.sv
module tb_biquad_serial_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] in_v [10];
  int          checks = 0;
  int          fails  = 0;

  logic        busy_m, done_m, busy_f, done_f, busy_s, done_s;
  logic [31:0] y_m, y_f, y_s;

  always #5 clk = ~clk;

  biquad_serial_eval #(.LAT(3)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .g0_i(in_v[0]), .g1_i(in_v[1]), .g2_i(in_v[2]), .h1_i(in_v[3]), .h2_i(in_v[4]),
    .x0_i(in_v[5]), .x1_i(in_v[6]), .x2_i(in_v[7]), .v1_i(in_v[8]), .v2_i(in_v[9]),
    .busy_o(busy_m), .done_o(done_m), .y_o(y_m));

  biquad_serial_eval #(.LAT(1)) dut_f (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .g0_i(in_v[0]), .g1_i(in_v[1]), .g2_i(in_v[2]), .h1_i(in_v[3]), .h2_i(in_v[4]),
    .x0_i(in_v[5]), .x1_i(in_v[6]), .x2_i(in_v[7]), .v1_i(in_v[8]), .v2_i(in_v[9]),
    .busy_o(busy_f), .done_o(done_f), .y_o(y_f));

  biquad_serial_eval #(.LAT(5)) dut_s (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .g0_i(in_v[0]), .g1_i(in_v[1]), .g2_i(in_v[2]), .h1_i(in_v[3]), .h2_i(in_v[4]),
    .x0_i(in_v[5]), .x1_i(in_v[6]), .x2_i(in_v[7]), .v1_i(in_v[8]), .v2_i(in_v[9]),
    .busy_o(busy_s), .done_o(done_s), .y_o(y_s));

  // operand order: g0 g1 g2 h1 h2 x0 x1 x2 v1 v2, then expected result
  localparam logic [31:0] VEC [10][11] = '{
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h12345678, 32'h7FFFFFFF, 32'h80000000, 32'h0BADF00D, 32'h33333333, 32'h0},
    '{32'h40000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h12345678, 32'h55555555, 32'h11111111, 32'h22222222, 32'h66666666, 32'h12345678},
    '{32'h20000000, 32'h20000000, 32'h0, 32'h0, 32'h0, 32'h20000000, 32'h10000000, 32'h0, 32'h0, 32'h0, 32'h18000000},
    '{32'h40000000, 32'h40000000, 32'h0, 32'h0, 32'h0, 32'h60000000, 32'h60000000, 32'h0, 32'h0, 32'h0, 32'h7FFFFFFF},
    '{32'h40000000, 32'h40000000, 32'h0, 32'h0, 32'h0, 32'hA0000000, 32'hA0000000, 32'h0, 32'h0, 32'h0, 32'h80000000},
    '{32'h80000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h80000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h7FFFFFFF},
    '{32'h00000001, 32'h0, 32'h0, 32'h0, 32'h0, 32'h20000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000001},
    '{32'h00000001, 32'h0, 32'h0, 32'h0, 32'h0, 32'hE0000000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
    '{32'h40000000, 32'h0, 32'h0, 32'hC0000000, 32'h20000000, 32'h08000000, 32'h0, 32'h0, 32'h10000000, 32'h20000000, 32'h08000000},
    '{32'h40000000, 32'h40000000, 32'hC0000000, 32'h0, 32'h0, 32'h60000000, 32'h60000000, 32'h40000000, 32'h0, 32'h0, 32'h3FFFFFFF}
  };
  // R1 zero gains, R1 unity, R1 mix, R3 high/low, R2 product clip, R2 rounding ties, R1 feedback, R10 order
  string vtag [10] = '{"R1", "R1", "R1", "R3", "R3", "R2", "R2", "R2", "R1", "R10"};

  function automatic logic [31:0] clip(input longint v);
    if (v > 64'sh7FFFFFFF)   return 32'h7FFFFFFF;
    if (v < -64'sh80000000)  return 32'h80000000;
    return v[31:0];
  endfunction

  function automatic logic [31:0] rmul(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    p = (p + (longint'(1) <<< 29)) >>> 30;
    return clip(p);
  endfunction

  function automatic logic [31:0] radd(input logic [31:0] a, input logic [31:0] b);
    return clip(longint'($signed(a)) + longint'($signed(b)));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic run_one(input logic [31:0] ops [10], input logic [31:0] expv,
                         input string tag, input bit poke);
    int t_m, t_f, t_s;
    logic [31:0] ym, yf, ys;
    t_m = -1; t_f = -1; t_s = -1;
    ym = '0; yf = '0; ys = '0;
    @(negedge clk);
    for (int i = 0; i < 10; i++) in_v[i] = ops[i];
    start = 1'b1;
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start = 1'b0;
        for (int i = 0; i < 10; i++) in_v[i] = $urandom; // R8 scramble
      end
      if (n == 2) chk(busy_m == 1'b1, "R5 busy after start", 32'(busy_m), 32'd1);
      if (poke && n == 4) begin
        start = 1'b1;                                   // R7 start while busy
        for (int i = 0; i < 10; i++) in_v[i] = $urandom;
      end
      if (poke && n == 5) start = 1'b0;
      if (done_f && t_f < 0) begin t_f = n; yf = y_f; end
      if (done_s && t_s < 0) begin t_s = n; ys = y_s; end
      if (done_m && t_m < 0) begin
        t_m = n; ym = y_m;
        chk(busy_m == 1'b0, "R5 busy low with done", 32'(busy_m), 32'd0);
      end
      if (t_m > 0 && n == t_m + 1) chk(done_m == 1'b0, "R5 done width", 32'(done_m), 32'd0);
      if (t_m > 0 && n == t_m + 3) chk(y_m == ym, "R6 result held", y_m, ym);
    end
    chk(ym == expv, {tag, " result LAT=3"}, ym, expv);
    chk(yf == expv, {tag, " result LAT=1"}, yf, expv);
    chk(ys == expv, {tag, " result LAT=5"}, ys, expv);
    chk(t_m == 37, "R4 latency LAT=3", 32'(t_m), 32'd37);
    chk(t_f == 19, "R4 latency LAT=1", 32'(t_f), 32'd19);
    chk(t_s == 55, "R4 latency LAT=5", 32'(t_s), 32'd55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] ops [10];
    logic [31:0] e;
    for (int i = 0; i < 10; i++) in_v[i] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy_m == 1'b0, "R9 reset busy", 32'(busy_m), 32'd0);
    chk(done_m == 1'b0, "R9 reset done", 32'(done_m), 32'd0);
    chk(y_m == 32'd0, "R9 reset result", y_m, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      for (int i = 0; i < 10; i++) ops[i] = VEC[v][i];
      run_one(ops, VEC[v][10], vtag[v], v[0]);
    end

    // random operands against the reference, R1 R2 R3 R7 R8
    for (int r = 0; r < 24; r++) begin
      for (int i = 0; i < 10; i++) begin
        ops[i] = $urandom;
        if (r[0]) ops[i] = 32'($signed(ops[i]) >>> 3);
      end
      e = radd(rmul(ops[0], ops[5]), rmul(ops[1], ops[6]));
      e = radd(e, rmul(ops[2], ops[7]));
      e = radd(e, rmul(ops[3], ops[8]));
      e = radd(e, rmul(ops[4], ops[9]));
      run_one(ops, e, "R1 random", r[1]);
    end

    // R9 reset in mid evaluation
    @(negedge clk);
    for (int i = 0; i < 10; i++) in_v[i] = VEC[1][i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy_m == 1'b0, "R9 abort busy", 32'(busy_m), 32'd0);
    chk(done_m == 1'b0, "R9 abort done", 32'(done_m), 32'd0);
    chk(y_m == 32'd0, "R9 abort result", y_m, 32'd0);
    repeat (2) @(negedge clk);
    chk(done_m == 1'b0, "R9 no late done", 32'(done_m), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) ops[i] = VEC[2][i];
    run_one(ops, VEC[2][10], "R9 after reset", 1'b0);

    finish_up();
  end

endmodule